// File: doc/BRIEF.md
# CEC Frame Transmitter

This block sends frames on a consumer-electronics-control line, a single open-drain wire that is low when any device pulls it. All timing is counted in ticks of a slow sample enable (`fs_tick`, about 32.768 kHz) that is applied to the fast system clock. When asked to send, the block first waits until the line has been high for a programmed number of bit cycles. It then drives the long start bit. After that it sends one 10-slot block per byte: eight data slots, most significant bit first, then an end-of-message slot, then an acknowledge slot.

In the acknowledge slot the block sends a logical 1 and then samples the line to see how the followers answered. Errors are collected over the whole frame and reported with a one-cycle done pulse after the last acknowledge slot. The start-bit and data-bit waveforms can each be made faster by trim fields. If another device holds the line low while this block has released it during a data or end-of-message slot, the frame stops and an arbitration-lost pulse is raised.

Up to `MAX_BYTES` bytes are taken from a flat data vector. Byte 0 is in bits [7:0] and is sent first. The frame length is given minus one.

Top module: `cec_frame_tx`

## Requirements
- R1: After reset, and whenever `tx_busy` is 0, `cec_drive_low` is 0, and `tx_done`, `tx_err` and `tx_arb_lost` are 0 out of reset.
- R2: All bit timing advances only on clock edges where `fs_tick` is 1. With one tick every N clocks, every width and period is N times its tick count.
- R3: After a start request, the first low drive begins after the line has been high for (free_m1+1)*P ticks in a row, where P = 79 - trim_dt_per. A low line seen during this wait restarts the whole wait.
- R4: The start bit is low for 121 - trim_st_rise ticks, and its total period is 147 - trim_st_per ticks.
- R5: A data slot carrying 1 is low for 20 - trim_dt_rise ticks, a slot carrying 0 is low for 49 - trim_dt_rise ticks, and each slot lasts 79 - trim_dt_per ticks. The acknowledge slot is driven as a 1.
- R6: A frame has 1 + 10*(tx_len_m1+1) low pulses. Each block is eight data bits MSB first, then an end-of-message bit that is 1 only in the last block, then the acknowledge slot.
- R7: The line is sampled at tick 34 of each acknowledge slot. When `tx_bcast` is 0, a high reading is an error. When `tx_bcast` is 1, a low reading is an error. `tx_done` pulses one cycle, P ticks after the last acknowledge slot begins, and `tx_err` is 1 in that same cycle if any block had an error.
- R8: A low line while the block is not driving, during a data or end-of-message slot, ends the frame. The block raises a one-cycle `tx_arb_lost`, drives no further pulses, and gives no `tx_done`.
- R9: `tx_busy` falls P ticks after `tx_done` or `tx_arb_lost`. A `tx_start` while busy is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| fs_tick | input | 1 | Sample-rate enable, one clock wide |
| tx_start | input | 1 | Start request, taken only when idle |
| tx_data | input | 8*MAX_BYTES | Frame bytes, byte 0 in bits [7:0] |
| tx_len_m1 | input | LEN_W | Number of bytes minus one |
| tx_bcast | input | 1 | Broadcast frame, flips acknowledge error sense |
| free_m1 | input | 4 | Bus-free wait in bit cycles minus one |
| trim_st_rise | input | 3 | Ticks removed from the start-bit low time |
| trim_st_per | input | 3 | Ticks removed from the start-bit period |
| trim_dt_rise | input | 3 | Ticks removed from data-slot low times |
| trim_dt_per | input | 3 | Ticks removed from the data-slot period |
| cec_line_in | input | 1 | Synchronized line level |
| cec_drive_low | output | 1 | 1 pulls the line low |
| tx_busy | output | 1 | Frame in progress, including wait and guard |
| tx_done | output | 1 | One-cycle frame completion pulse |
| tx_err | output | 1 | Acknowledge error, valid with tx_done |
| tx_arb_lost | output | 1 | One-cycle arbitration-lost pulse |

## Verification
Each result is due a fixed number of ticks after its cause. The first low drive comes (free_m1+1)*P ticks after the accepting edge, or after the last low line cycle of the wait. `tx_done` comes P ticks after the last acknowledge slot starts, and `tx_busy` falls P ticks after that. Every pulse width and period is a whole number of ticks times the tick spacing. The bench samples at falling clock edges and stamps each edge of `cec_drive_low` with a cycle counter. It checks the differences between stamps against the tick counts above, so the checks do not rely on any particular sampling cycle.

// File: rtl/cec_tx_pkg.sv
// Shared types and nominal tick counts for the frame transmitter.
// Assumes all timing is expressed in fs ticks.
package cec_tx_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_FREE,
        ST_START,
        ST_DATA,
        ST_GUARD
    } tx_state_e;

    localparam int START_LOW_TICKS  = 121;
    localparam int START_PER_TICKS  = 147;
    localparam int SLOT_PER_TICKS   = 79;
    localparam int ONE_LOW_TICKS    = 20;
    localparam int ZERO_LOW_TICKS   = 49;
    localparam int ACK_SAMPLE_TICK  = 34;
    localparam int SLOTS_PER_BLOCK  = 10;
endpackage

// File: rtl/cec_bit_timer.sv
// Tick counter for one bit slot: counts 0..period-1 on fs_tick and wraps.
// Assumes period is at least 2 and does not change within a slot.
module cec_bit_timer #(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic             clr,
    input  logic [CNT_W-1:0] period,
    output logic [CNT_W-1:0] cnt,
    output logic             slot_end
);
    logic at_last;
    assign at_last  = (cnt == period - CNT_W'(1));
    assign slot_end = tick && !clr && at_last;

    // Advance the position within the slot on each tick, wrap at the period.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (clr) begin
            cnt <= '0;
        end else if (tick) begin
            cnt <= at_last ? '0 : cnt + CNT_W'(1);
        end
    end
endmodule

// File: rtl/cec_bit_shaper.sv
// Computes the low time and period of the current slot from the trims.
// Assumes trims are smaller than every nominal value (purely combinational).
module cec_bit_shaper
    import cec_tx_pkg::*;
#(
    parameter int CNT_W  = 8,
    parameter int TRIM_W = 3
) (
    input  logic              is_start,
    input  logic              bit_val,
    input  logic [TRIM_W-1:0] st_rise,
    input  logic [TRIM_W-1:0] st_per,
    input  logic [TRIM_W-1:0] dt_rise,
    input  logic [TRIM_W-1:0] dt_per,
    output logic [CNT_W-1:0]  low_ticks,
    output logic [CNT_W-1:0]  per_ticks
);
    localparam int PAD = CNT_W - TRIM_W;

    logic [CNT_W-1:0] data_low;

    // Pick the nominal data low time, then subtract the applicable trim.
    always_comb begin
        data_low = bit_val ? CNT_W'(ONE_LOW_TICKS) : CNT_W'(ZERO_LOW_TICKS);
        if (is_start) begin
            low_ticks = CNT_W'(START_LOW_TICKS) - {{PAD{1'b0}}, st_rise};
            per_ticks = CNT_W'(START_PER_TICKS) - {{PAD{1'b0}}, st_per};
        end else begin
            low_ticks = data_low - {{PAD{1'b0}}, dt_rise};
            per_ticks = CNT_W'(SLOT_PER_TICKS) - {{PAD{1'b0}}, dt_per};
        end
    end
endmodule

// File: rtl/cec_free_gate.sv
// Counts whole bit cycles of high line; fires when the target count is reached.
// Assumes the caller clears it whenever the line is low or the wait is not active.
module cec_free_gate #(
    parameter int FREE_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr,
    input  logic              slot_end,
    input  logic [FREE_W-1:0] target,
    output logic              free_ok
);
    logic [FREE_W-1:0] seen;

    assign free_ok = slot_end && !clr && (seen == target);

    // Tally completed high bit cycles since the last clear.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            seen <= '0;
        end else if (slot_end) begin
            seen <= seen + FREE_W'(1);
        end
    end
endmodule

// File: rtl/cec_frame_tx.sv
// Frame transmitter: bus-free wait, start bit, 10-slot blocks, ACK check.
// Assumes cec_line_in is already synchronized to clk and fs_tick is one clk wide.
module cec_frame_tx
    import cec_tx_pkg::*;
#(
    parameter int MAX_BYTES = 4,
    parameter int CNT_W     = 8,
    parameter int FREE_W    = 4,
    parameter int TRIM_W    = 3,
    localparam int LEN_W    = (MAX_BYTES > 1) ? $clog2(MAX_BYTES) : 1,
    localparam int DATA_W   = MAX_BYTES * 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              fs_tick,
    input  logic              tx_start,
    input  logic [DATA_W-1:0] tx_data,
    input  logic [LEN_W-1:0]  tx_len_m1,
    input  logic              tx_bcast,
    input  logic [FREE_W-1:0] free_m1,
    input  logic [TRIM_W-1:0] trim_st_rise,
    input  logic [TRIM_W-1:0] trim_st_per,
    input  logic [TRIM_W-1:0] trim_dt_rise,
    input  logic [TRIM_W-1:0] trim_dt_per,
    input  logic              cec_line_in,
    output logic              cec_drive_low,
    output logic              tx_busy,
    output logic              tx_done,
    output logic              tx_err,
    output logic              tx_arb_lost
);
    localparam logic [3:0] EOM_SLOT = 4'd8;
    localparam logic [3:0] ACK_SLOT = 4'(SLOTS_PER_BLOCK - 1);

    tx_state_e         st;
    logic [DATA_W-1:0] data_q;
    logic [LEN_W-1:0]  len_q;
    logic              bcast_q;
    logic [FREE_W-1:0] free_q;
    logic [TRIM_W-1:0] st_rise_q, st_per_q, dt_rise_q, dt_per_q;
    logic [LEN_W-1:0]  byte_idx;
    logic [3:0]        slot_idx;
    logic              err_acc;

    logic [7:0]        cur_byte;
    logic              cur_bit;
    logic              line_low;
    logic              driving;
    logic              arb_hit;
    logic              ack_sample;
    logic              ack_bad;
    logic              timer_clr;
    logic              free_clr;
    logic              free_ok;
    logic              slot_end;
    logic [CNT_W-1:0]  cnt;
    logic [CNT_W-1:0]  low_ticks;
    logic [CNT_W-1:0]  per_ticks;

    assign line_low = !cec_line_in;
    assign cur_byte = data_q[{byte_idx, 3'b000} +: 8];

    // Value carried by the current slot: data MSB first, EOM, then ACK as 1.
    always_comb begin
        if (slot_idx < EOM_SLOT) begin
            cur_bit = cur_byte[3'd7 - slot_idx[2:0]];
        end else if (slot_idx == EOM_SLOT) begin
            cur_bit = (byte_idx == len_q);
        end else begin
            cur_bit = 1'b1;
        end
    end

    cec_bit_shaper #(.CNT_W(CNT_W), .TRIM_W(TRIM_W)) u_shaper (
        .is_start  (st == ST_START),
        .bit_val   (cur_bit),
        .st_rise   (st_rise_q),
        .st_per    (st_per_q),
        .dt_rise   (dt_rise_q),
        .dt_per    (dt_per_q),
        .low_ticks (low_ticks),
        .per_ticks (per_ticks)
    );

    assign driving    = ((st == ST_START) || (st == ST_DATA)) && (cnt < low_ticks);
    assign arb_hit    = (st == ST_DATA) && (slot_idx < ACK_SLOT) && !driving && line_low;
    assign ack_sample = (st == ST_DATA) && (slot_idx == ACK_SLOT) && fs_tick
                        && (cnt == CNT_W'(ACK_SAMPLE_TICK));
    assign ack_bad    = bcast_q ? line_low : !line_low;
    assign timer_clr  = (st == ST_IDLE) || ((st == ST_FREE) && line_low) || arb_hit;
    assign free_clr   = (st != ST_FREE) || line_low;

    cec_bit_timer #(.CNT_W(CNT_W)) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .tick     (fs_tick),
        .clr      (timer_clr),
        .period   (per_ticks),
        .cnt      (cnt),
        .slot_end (slot_end)
    );

    cec_free_gate #(.FREE_W(FREE_W)) u_free (
        .clk      (clk),
        .rst_n    (rst_n),
        .clr      (free_clr),
        .slot_end (slot_end),
        .target   (free_q),
        .free_ok  (free_ok)
    );

    assign cec_drive_low = driving;
    assign tx_busy       = (st != ST_IDLE);

    // Frame sequencing, configuration capture and result pulses.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st          <= ST_IDLE;
            data_q      <= '0;
            len_q       <= '0;
            bcast_q     <= 1'b0;
            free_q      <= '0;
            st_rise_q   <= '0;
            st_per_q    <= '0;
            dt_rise_q   <= '0;
            dt_per_q    <= '0;
            byte_idx    <= '0;
            slot_idx    <= '0;
            err_acc     <= 1'b0;
            tx_done     <= 1'b0;
            tx_err      <= 1'b0;
            tx_arb_lost <= 1'b0;
        end else begin
            tx_done     <= 1'b0;
            tx_err      <= 1'b0;
            tx_arb_lost <= 1'b0;
            case (st)
                ST_IDLE: begin
                    if (tx_start) begin
                        data_q    <= tx_data;
                        len_q     <= tx_len_m1;
                        bcast_q   <= tx_bcast;
                        free_q    <= free_m1;
                        st_rise_q <= trim_st_rise;
                        st_per_q  <= trim_st_per;
                        dt_rise_q <= trim_dt_rise;
                        dt_per_q  <= trim_dt_per;
                        err_acc   <= 1'b0;
                        st        <= ST_FREE;
                    end
                end
                ST_FREE: begin
                    if (free_ok) st <= ST_START;
                end
                ST_START: begin
                    if (slot_end) begin
                        st       <= ST_DATA;
                        slot_idx <= '0;
                        byte_idx <= '0;
                    end
                end
                ST_DATA: begin
                    if (arb_hit) begin
                        tx_arb_lost <= 1'b1;
                        st          <= ST_GUARD;
                    end else begin
                        if (ack_sample && ack_bad) err_acc <= 1'b1;
                        if (slot_end) begin
                            if (slot_idx == ACK_SLOT) begin
                                slot_idx <= '0;
                                if (byte_idx == len_q) begin
                                    tx_done <= 1'b1;
                                    tx_err  <= err_acc;
                                    st      <= ST_GUARD;
                                end else begin
                                    byte_idx <= byte_idx + LEN_W'(1);
                                end
                            end else begin
                                slot_idx <= slot_idx + 4'd1;
                            end
                        end
                    end
                end
                ST_GUARD: begin
                    if (slot_end) st <= ST_IDLE;
                end
                default: st <= ST_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/cec_frame_tx_chk.sv
// Property checker for the frame transmitter, attached by bind.
// Assumes the same clock and synchronous active-low reset as the design.
module cec_frame_tx_chk (
    input logic clk,
    input logic rst_n,
    input logic fs_tick,
    input logic cec_drive_low,
    input logic tx_busy,
    input logic tx_done,
    input logic tx_err,
    input logic tx_arb_lost
);
    a_r1_idle_released: assert property (@(posedge clk) disable iff (!rst_n)
        !tx_busy |-> !cec_drive_low);

    a_r2_frozen_without_tick: assert property (@(posedge clk) disable iff (!rst_n)
        !fs_tick |=> $stable(cec_drive_low));

    a_r7_err_only_with_done: assert property (@(posedge clk) disable iff (!rst_n)
        tx_err |-> tx_done);

    a_r7_done_single_cycle: assert property (@(posedge clk) disable iff (!rst_n)
        tx_done |=> !tx_done);

    a_r8_arb_excludes_done: assert property (@(posedge clk) disable iff (!rst_n)
        !(tx_done && tx_arb_lost));

    a_r8_arb_line_released: assert property (@(posedge clk) disable iff (!rst_n)
        tx_arb_lost |-> (!cec_drive_low && tx_busy));

    a_r9_done_in_guard: assert property (@(posedge clk) disable iff (!rst_n)
        tx_done |-> tx_busy);
endmodule

bind cec_frame_tx cec_frame_tx_chk u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .fs_tick       (fs_tick),
    .cec_drive_low (cec_drive_low),
    .tx_busy       (tx_busy),
    .tx_done       (tx_done),
    .tx_err        (tx_err),
    .tx_arb_lost   (tx_arb_lost)
);

// File: tb/cec_frame_tx_test.sv
// Directed bench: one task per scenario, waveform measured by edge stamps.
module cec_frame_tx_test;
    localparam int MAXB = 4;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        fs_tick = 1'b1;
    logic        tx_start = 1'b0;
    logic [31:0] tx_data = '0;
    logic [1:0]  tx_len_m1 = '0;
    logic        tx_bcast = 1'b0;
    logic [3:0]  free_m1 = '0;
    logic [2:0]  trim_st_rise = '0, trim_st_per = '0, trim_dt_rise = '0, trim_dt_per = '0;
    logic        cec_line_in;
    logic        cec_drive_low, tx_busy, tx_done, tx_err, tx_arb_lost;

    logic        intruder_low = 1'b0;
    int          ack_hold = 0;
    logic        ack_en = 1'b0;
    int          tick_div = 1;
    int          tick_ph = 0;

    int cyc = 0;
    int checks = 0;
    int fails = 0;
    int fall_cyc [0:63];
    int rise_cyc [0:63];
    int nfall = 0, nrise = 0;
    int done_cnt = 0, done_cyc = 0, arb_cnt = 0;
    logic err_seen = 1'b0;
    logic prev_drive = 1'b0;

    assign cec_line_in = !(cec_drive_low || (ack_hold > 0) || intruder_low);

    cec_frame_tx #(.MAX_BYTES(MAXB)) uut (
        .clk(clk), .rst_n(rst_n), .fs_tick(fs_tick), .tx_start(tx_start),
        .tx_data(tx_data), .tx_len_m1(tx_len_m1), .tx_bcast(tx_bcast),
        .free_m1(free_m1), .trim_st_rise(trim_st_rise), .trim_st_per(trim_st_per),
        .trim_dt_rise(trim_dt_rise), .trim_dt_per(trim_dt_per),
        .cec_line_in(cec_line_in), .cec_drive_low(cec_drive_low), .tx_busy(tx_busy),
        .tx_done(tx_done), .tx_err(tx_err), .tx_arb_lost(tx_arb_lost)
    );

    always #5 clk = ~clk;

    always @(posedge clk) cyc <= cyc + 1;

    // Tick generator, follower model and edge monitor, all at falling edges.
    always @(negedge clk) begin
        if (tick_div <= 1) begin
            fs_tick = 1'b1;
            tick_ph = 0;
        end else begin
            tick_ph = (tick_ph + 1) % tick_div;
            fs_tick = (tick_ph == 0);
        end
        if (ack_hold > 0) ack_hold = ack_hold - 1;
        if (cec_drive_low && !prev_drive) begin
            if (nfall < 64) fall_cyc[nfall] = cyc;
            if (ack_en && nfall >= 1 && ((nfall - 1) % 10) == 9) ack_hold = 49;
            nfall = nfall + 1;
        end
        if (!cec_drive_low && prev_drive) begin
            if (nrise < 64) rise_cyc[nrise] = cyc;
            nrise = nrise + 1;
        end
        prev_drive = cec_drive_low;
        if (tx_done) begin
            done_cnt = done_cnt + 1;
            done_cyc = cyc;
            err_seen = tx_err;
        end
        if (tx_arb_lost) arb_cnt = arb_cnt + 1;
    end

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s act=%0d exp=%0d", tag, act, exp);
        end
    endtask

    task automatic clear_mon();
        nfall = 0; nrise = 0; done_cnt = 0; arb_cnt = 0; err_seen = 1'b0;
    endtask

    // Pulse start and return the stamp of the accepting edge.
    task automatic kick(output int t0);
        @(negedge clk);
        tx_start = 1'b1;
        @(negedge clk);
        tx_start = 1'b0;
        t0 = cyc;
    endtask

    task automatic wait_end();
        for (int i = 0; i < 40000; i++) begin
            if (done_cnt > 0 || arb_cnt > 0) break;
            @(negedge clk);
        end
    endtask

    function automatic int exp_bit(input logic [7:0] b, input int slot, input bit last);
        if (slot < 8) return int'(b[7 - slot]);
        if (slot == 8) return last ? 1 : 0;
        return 1;
    endfunction

    // Compare the recorded waveform against the expected frame.
    task automatic check_wave(input int nbytes, input logic [31:0] bytes, input int div);
        int p = 79 - int'(trim_dt_per);
        chk("R6 pulse count", nfall, 1 + 10 * nbytes);
        chk("R4 start low", rise_cyc[0] - fall_cyc[0], (121 - int'(trim_st_rise)) * div);
        chk("R4 start period", fall_cyc[1] - fall_cyc[0], (147 - int'(trim_st_per)) * div);
        for (int k = 0; k < nbytes * 10; k++) begin
            int i = k + 1;
            int bv = exp_bit(bytes[(k / 10) * 8 +: 8], k % 10, (k / 10) == nbytes - 1);
            int lw = (bv != 0) ? 20 : 49;
            chk($sformatf("R5 R6 slot %0d low", k), rise_cyc[i] - fall_cyc[i],
                (lw - int'(trim_dt_rise)) * div);
            if (i + 1 < nfall)
                chk($sformatf("R5 slot %0d period", k), fall_cyc[i + 1] - fall_cyc[i], p * div);
        end
        chk("R7 done timing", done_cyc, fall_cyc[nfall - 1] + p * div);
    endtask

    task automatic t_reset();
        chk("R1 reset drive", int'(cec_drive_low), 0);
        chk("R1 reset busy", int'(tx_busy), 0);
        chk("R1 reset done", int'(tx_done), 0);
        chk("R1 reset arb", int'(tx_arb_lost), 0);
    endtask

    task automatic t_basic();
        int t0, settled;
        clear_mon();
        tx_data = 32'h0000_00A5; tx_len_m1 = 2'd0; tx_bcast = 1'b0; free_m1 = 4'd0;
        trim_st_rise = 0; trim_st_per = 0; trim_dt_rise = 0; trim_dt_per = 0;
        ack_en = 1'b1;
        kick(t0);
        while (nfall < 5) @(negedge clk);
        tx_start = 1'b1;
        @(negedge clk);
        tx_start = 1'b0;
        wait_end();
        chk("R3 free wait one cycle", fall_cyc[0] - t0, 79);
        check_wave(1, tx_data, 1);
        chk("R7 unicast acked done", done_cnt, 1);
        chk("R7 unicast acked err", int'(err_seen), 0);
        chk("R8 no arb on ack", arb_cnt, 0);
        while (tx_busy) @(negedge clk);
        chk("R9 guard length", cyc - done_cyc, 79);
        settled = nfall;
        repeat (2000) @(negedge clk);
        chk("R9 busy start ignored pulses", nfall, settled);
        chk("R9 busy start ignored idle", int'(tx_busy), 0);
    endtask

    task automatic t_trim();
        int t0;
        clear_mon();
        tx_data = 32'h0000_813C; tx_len_m1 = 2'd1; tx_bcast = 1'b0; free_m1 = 4'd2;
        trim_st_rise = 3'd7; trim_st_per = 3'd7; trim_dt_rise = 3'd5; trim_dt_per = 3'd3;
        ack_en = 1'b1;
        kick(t0);
        wait_end();
        chk("R3 free wait three cycles", fall_cyc[0] - t0, 3 * 76);
        check_wave(2, tx_data, 1);
        chk("R7 two bytes err", int'(err_seen), 0);
        while (tx_busy) @(negedge clk);
    endtask

    task automatic t_tick_noack();
        int t0;
        clear_mon();
        tx_data = 32'h0000_005A; tx_len_m1 = 2'd0; tx_bcast = 1'b0; free_m1 = 4'd0;
        trim_st_rise = 0; trim_st_per = 0; trim_dt_rise = 0; trim_dt_per = 0;
        ack_en = 1'b0;
        tick_div = 3;
        kick(t0);
        wait_end();
        chk("R2 start low scaled", rise_cyc[0] - fall_cyc[0], 363);
        check_wave(1, tx_data, 3);
        chk("R7 unicast no ack err", int'(err_seen), 1);
        while (tx_busy) @(negedge clk);
        tick_div = 1;
        repeat (5) @(negedge clk);
    endtask

    task automatic t_bcast();
        int t0;
        clear_mon();
        tx_data = 32'h0000_0F0F; tx_len_m1 = 2'd1; tx_bcast = 1'b1; free_m1 = 4'd0;
        ack_en = 1'b1;
        kick(t0);
        wait_end();
        chk("R7 broadcast low ack err", int'(err_seen), 1);
        while (tx_busy) @(negedge clk);
        clear_mon();
        ack_en = 1'b0;
        kick(t0);
        wait_end();
        chk("R7 broadcast high ack err", int'(err_seen), 0);
        chk("R7 broadcast done", done_cnt, 1);
        while (tx_busy) @(negedge clk);
        tx_bcast = 1'b0;
    endtask

    task automatic t_arb();
        int t0;
        clear_mon();
        tx_data = 32'h0000_00FF; tx_len_m1 = 2'd0; free_m1 = 4'd0; ack_en = 1'b0;
        kick(t0);
        while (nfall < 2) @(negedge clk);
        repeat (30) @(negedge clk);
        intruder_low = 1'b1;
        repeat (4) @(negedge clk);
        intruder_low = 1'b0;
        repeat (1000) @(negedge clk);
        chk("R8 arb pulse", arb_cnt, 1);
        chk("R8 no done", done_cnt, 0);
        chk("R8 no further pulses", nfall, 2);
        chk("R8 back to idle", int'(tx_busy), 0);
    endtask

    task automatic t_free_restart();
        int t0, c2;
        clear_mon();
        tx_data = 32'h0000_0042; tx_len_m1 = 2'd0; free_m1 = 4'd1; ack_en = 1'b1;
        kick(t0);
        repeat (50) @(negedge clk);
        intruder_low = 1'b1;
        repeat (3) @(negedge clk);
        intruder_low = 1'b0;
        c2 = cyc;
        wait_end();
        chk("R3 wait restarts on low", fall_cyc[0], c2 + 2 * 79);
        chk("R3 frame still sent", done_cnt, 1);
        while (tx_busy) @(negedge clk);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        fails++;
        $display("FAIL watchdog act=%0d exp=%0d", cyc, 0);
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        t_reset();
        t_basic();
        t_trim();
        t_tick_noack();
        t_bcast();
        t_arb();
        t_free_restart();
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule